// File: doc/BRIEF.md
# Two-Wire Bus Clock-Low Timeout Monitor

This block sits next to the protocol engine of a two-wire serial slave and watches the bus clock and data lines. It first synchronizes both lines and filters out short noise pulses. On the clean lines it finds transaction boundaries: a START is data falling while the clock is high, and a STOP is data rising while the clock is high. Between a START and the matching STOP it measures how long the clock line has been held low without a break.

If the clock stays low past a trip point at 30 ms, the block does three things. It sends a one-cycle reset pulse to the protocol engine. It raises a request that makes the slave stop driving the data line. It marks the bus as idle so that the next START is accepted as a new transaction. The trip point is set from a clock-ticks-per-millisecond parameter, inside a window whose lower edge is 25 ms and upper edge is 35 ms. Clock-low time outside an open transaction is never counted, so a host that parks the clock low while the bus is idle causes no reset.

The data-release request stays raised after a timeout until the next START is seen. The bus-busy flag shows whether a transaction is open.

Top module: `smbus_tmo_monitor`

## Requirements
- R1: A START (data falls while clock is high, on the filtered lines) sets `busy_o`. A STOP (data rises while clock is high) clears `busy_o`. A repeated START while busy keeps `busy_o` set.
- R2: While `busy_o` is low, clock-low time is not counted, and no timeout pulse is produced however long the clock stays low.
- R3: Inside a transaction, a clock-low stretch shorter than `GUARD_LO_MS` (25 ms) produces no timeout pulse.
- R4: Inside a transaction, a clock-low stretch that reaches `GUARD_HI_MS` (35 ms) always produces a timeout pulse. The pulse comes from a trip point of `TRIP_MS` (30 ms) times `TICKS_PER_MS` filtered low cycles.
- R5: `tmo_rst_o` is high for exactly one cycle per timeout. `busy_o` is already low in that same cycle.
- R6: `sda_rel_o` rises together with the timeout pulse. It stays high until the next START. A STOP does not clear it. A START clears it.
- R7: A level change on either line that lasts fewer than `FILT_CYC` clock cycles is ignored and neither opens nor closes a transaction.
- R8: The low-time count restarts on every rising clock edge and on every START or STOP. Low stretches that are each shorter than the lower guard therefore never add up to a timeout.
- R9: After reset, `tmo_rst_o`, `sda_rel_o` and `busy_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Raw bus clock line level |
| sda_i | input | 1 | Raw bus data line level |
| tmo_rst_o | output | 1 | One-cycle reset pulse to the slave protocol engine |
| sda_rel_o | output | 1 | Request to stop driving the data line, held until the next START |
| busy_o | output | 1 | High while a transaction is open |

## Verification
The main timeout path is tried with clock-low stretches of four lengths inside an open transaction: well under the lower guard, just under it, just above the trip point, and well beyond it. These show that 24 ms of low time is tolerated and that 33 ms always trips. For each stretch that trips, the cycle of the pulse is measured from the raw clock edge and must fall inside the guard window. Separate patterns cover:
- a long low clock with no transaction open, which must cause no trip;
- two sub-guard stretches joined by a clock pulse, and a repeated START, which show the count restarts;
- data pulses shorter than the filter window;
- a STOP after a timeout, which must leave the release request up until the next START.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int LINE_SCL  = 0;
  localparam int LINE_SDA  = 1;
  localparam int NUM_LINES = 2;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
  } tmon_evt_t;
endpackage

// File: rtl/tmon_line_filter.sv
module tmon_line_filter #(
  parameter int FILT_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic         meta_q, sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      clean_o <= 1'b1;
    end else if (sync_q == clean_o) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      run_q   <= '0;
      clean_o <= sync_q;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmon_cond_detect.sv
module tmon_cond_detect
  import tmon_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      scl_c,
  input  logic      sda_c,
  output tmon_evt_t evt_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_c;
      sda_q <= sda_c;
    end
  end

  always_comb begin
    evt_o.start    = scl_c && scl_q && sda_q && !sda_c;
    evt_o.stop     = scl_c && scl_q && !sda_q && sda_c;
    evt_o.scl_rise = scl_c && !scl_q;
  end
endmodule

// File: rtl/tmon_low_timer.sv
module tmon_low_timer
  import tmon_pkg::*;
#(
  parameter int TRIP_TICKS = 6000000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      open_i,
  input  logic      scl_c,
  input  tmon_evt_t evt_i,
  output logic      trip_o
);
  localparam int CW = $clog2(TRIP_TICKS + 1);
  localparam logic [CW-1:0] TRIP_M1 = CW'(TRIP_TICKS - 1);
  localparam logic [CW-1:0] TRIP_V  = CW'(TRIP_TICKS);

  logic [CW-1:0] low_q;
  logic          restart;

  assign restart = !open_i || evt_i.start || evt_i.stop || evt_i.scl_rise;
  assign trip_o  = !restart && !scl_c && (low_q == TRIP_M1);

  always_ff @(posedge clk) begin
    if (rst || restart)
      low_q <= '0;
    else if (!scl_c && low_q != TRIP_V)
      low_q <= low_q + 1'b1;
  end
endmodule

// File: rtl/smbus_tmo_monitor.sv
module smbus_tmo_monitor
  import tmon_pkg::*;
#(
  parameter int TICKS_PER_MS = 200000,
  parameter int TRIP_MS      = 30,
  parameter int GUARD_LO_MS  = 25,
  parameter int GUARD_HI_MS  = 35,
  parameter int FILT_CYC     = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic tmo_rst_o,
  output logic sda_rel_o,
  output logic busy_o
);
  localparam int TRIP_TICKS = TICKS_PER_MS * TRIP_MS;

  logic [NUM_LINES-1:0] raw_lines, clean_lines;
  logic                 scl_clean, sda_clean, trip;
  tmon_evt_t            evt;

  assign raw_lines[LINE_SCL] = scl_i;
  assign raw_lines[LINE_SDA] = sda_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    tmon_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (raw_lines[g]),
      .clean_o(clean_lines[g])
    );
  end

  assign scl_clean = clean_lines[LINE_SCL];
  assign sda_clean = clean_lines[LINE_SDA];

  tmon_cond_detect u_cond (
    .clk  (clk),
    .rst  (rst),
    .scl_c(scl_clean),
    .sda_c(sda_clean),
    .evt_o(evt)
  );

  tmon_low_timer #(.TRIP_TICKS(TRIP_TICKS)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .open_i(busy_o),
    .scl_c (scl_clean),
    .evt_i (evt),
    .trip_o(trip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o    <= 1'b0;
      tmo_rst_o <= 1'b0;
      sda_rel_o <= 1'b0;
    end else begin
      tmo_rst_o <= trip;
      if (trip)           busy_o <= 1'b0;
      else if (evt.start) busy_o <= 1'b1;
      else if (evt.stop)  busy_o <= 1'b0;
      if (trip)           sda_rel_o <= 1'b1;
      else if (evt.start) sda_rel_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tmon_checker.sv
module tmon_checker #(
  parameter int MIN_TICKS = 500,
  parameter int MAX_TICKS = 700
) (
  input logic clk,
  input logic rst,
  input logic scl_clean,
  input logic busy,
  input logic tmo,
  input logic rel
);
  localparam int CW = $clog2(MAX_TICKS + 2);
  localparam logic [CW-1:0] SAT = CW'(MAX_TICKS + 1);
  localparam logic [CW-1:0] LO  = CW'(MIN_TICKS);
  localparam logic [CW-1:0] HI  = CW'(MAX_TICKS);

  logic [CW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || !busy || scl_clean) low_run <= '0;
    else if (low_run != SAT)       low_run <= low_run + 1'b1;
  end

  AST_TMO_SINGLE:  assert property (@(posedge clk) disable iff (rst) tmo |=> !tmo);            // R5
  AST_TMO_IDLE:    assert property (@(posedge clk) disable iff (rst) tmo |-> !busy);           // R5
  AST_TMO_OPEN:    assert property (@(posedge clk) disable iff (rst) tmo |-> $past(busy));     // R2
  AST_NO_EARLY:    assert property (@(posedge clk) disable iff (rst) tmo |-> (low_run >= LO)); // R3
  AST_NO_LATE:     assert property (@(posedge clk) disable iff (rst) busy |-> (low_run < HI)); // R4
  AST_REL_SET:     assert property (@(posedge clk) disable iff (rst) tmo |-> rel);             // R6
  AST_REL_HOLD:    assert property (@(posedge clk) disable iff (rst) rel |=> (rel || busy));   // R6
endmodule

bind smbus_tmo_monitor tmon_checker #(
  .MIN_TICKS(TICKS_PER_MS * GUARD_LO_MS),
  .MAX_TICKS(TICKS_PER_MS * GUARD_HI_MS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_clean(scl_clean),
  .busy     (busy_o),
  .tmo      (tmo_rst_o),
  .rel      (sda_rel_o)
);

// File: tb/smbus_tmo_monitor_bench.sv
`timescale 1ns/1ps
module smbus_tmo_monitor_bench;
  localparam int TPM  = 20;
  localparam int FILT = 10;
  localparam int LO_T = TPM * 25;
  localparam int HI_T = TPM * 35;
  localparam int NV   = 4;
  localparam int VEC_LOW [NV] = '{100, 480, 660, 800};
  localparam bit VEC_TMO [NV] = '{1'b0, 1'b0, 1'b1, 1'b1};

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda = 1'b1;
  logic tmo, rel, busy;
  int   n_chk = 0, n_bad = 0, cyc = 0, pcnt = 0, plast = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  smbus_tmo_monitor #(.TICKS_PER_MS(TPM), .FILT_CYC(FILT)) u_smbus_tmo_monitor (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
    .tmo_rst_o(tmo), .sda_rel_o(rel), .busy_o(busy)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (tmo) begin
      pcnt  <= pcnt + 1;
      plast <= cyc;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    idle(150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int p0, t0;
    idle(4);
    chk("R9 tmo after reset", tmo, 0);
    chk("R9 rel after reset", rel, 0);
    chk("R9 busy after reset", busy, 0);
    rst = 1'b0;
    idle(30);

    for (int v = 0; v < NV; v++) begin
      sda = 1'b0; idle(30);                                  // START
      chk("R1 busy after START", busy, 1);
      if (v > 0 && VEC_TMO[v-1]) chk("R6 START clears release", rel, 0);
      p0 = pcnt; t0 = cyc;
      scl = 1'b0; idle(VEC_LOW[v]);
      if (!VEC_TMO[v]) begin
        scl = 1'b1; idle(30);
        chk("R3 no pulse below lower guard", pcnt - p0, 0);
        chk("R1 busy held", busy, 1);
        sda = 1'b1; idle(30);                                // STOP
        chk("R1 busy cleared by STOP", busy, 0);
      end else begin
        chk("R5 exactly one pulse", pcnt - p0, 1);
        chk("R4 pulse inside window", int'((plast - t0) >= LO_T && (plast - t0) < HI_T), 1);
        chk("R5 busy cleared by timeout", busy, 0);
        chk("R6 release raised", rel, 1);
        scl = 1'b1; idle(30);
        sda = 1'b1; idle(30);                                // STOP with no open transaction
        chk("R6 release kept after STOP", rel, 1);
      end
    end

    // R6: release is cleared only by a START
    sda = 1'b0; idle(30);
    chk("R6 release cleared by START", rel, 0);
    sda = 1'b1; idle(30);

    // R2: clock parked low with no transaction open
    p0 = pcnt;
    scl = 1'b0; idle(900);
    chk("R2 no pulse while idle", pcnt - p0, 0);
    chk("R2 busy stays low", busy, 0);
    scl = 1'b1; idle(30);

    // R7: short data pulses do not form START or STOP
    sda = 1'b0; idle(FILT - 4); sda = 1'b1; idle(30);
    chk("R7 short low pulse no START", busy, 0);
    sda = 1'b0; idle(30);
    chk("R7 long low pulse is START", busy, 1);
    sda = 1'b1; idle(FILT - 4); sda = 1'b0; idle(30);
    chk("R7 short high pulse no STOP", busy, 1);

    // R8: clock pulse restarts the count
    p0 = pcnt;
    scl = 1'b0; idle(400); scl = 1'b1; idle(30); scl = 1'b0; idle(400);
    chk("R8 clock edge restarts count", pcnt - p0, 0);
    chk("R8 busy still open", busy, 1);
    scl = 1'b1; idle(30);
    sda = 1'b1; idle(30);

    // R8 and R1: a repeated START restarts the count and keeps the transaction open
    sda = 1'b0; idle(30);
    scl = 1'b0; idle(400);
    sda = 1'b1; idle(20); scl = 1'b1; idle(30);
    sda = 1'b0; idle(30);                                    // repeated START
    chk("R1 repeated START keeps busy", busy, 1);
    p0 = pcnt;
    scl = 1'b0; idle(400);
    chk("R8 repeated START no pulse", pcnt - p0, 0);
    idle(400);
    chk("R4 long low after repeated START trips", pcnt - p0, 1);
    chk("R5 busy low after trip", busy, 0);
    finish_run();
  end
endmodule